// File: doc/BRIEF.md
# Two-Level Debug Breakpoint Trigger Unit

This unit observes every retired processor access (program counter, bus address and bus data, qualified by a valid strobe) and decides whether it matches a programmed breakpoint. Six configuration registers hold a PC base, a PC don't-care mask, a low and a high address bound, a data value and a control word. The control word gives each of two trigger levels its own enable, comparator selection, inversions and a combining mode. That mode either ANDs the PC condition with the address-and-data condition, or ORs the two.

In single-level operation the final trigger follows the level-1 hit. In double-level operation a level-1 hit arms the unit. Level 2 is evaluated only while the unit is armed. When it matches, it produces a one-cycle trigger pulse and disarms the unit. Every result is registered, so each output appears in the cycle after the access that caused it.

Top module: `dbg_trig_unit`

## Requirements
- R1: After reset the control word and all other configuration registers are zero, and `l1_hit`, `l2_hit` and `trig` are low. No access produces a hit until the unit is configured.
- R2: A write (`wr_en` high) loads `wr_data` into the register selected by `wr_addr`: 0 control, 1 PC base, 2 PC mask, 3 address low bound, 4 address high bound, 5 data value. The write takes effect for accesses in the following cycle. Control bits 8:0 configure level 1 and bits 17:9 configure level 2, with the same layout in both. Bit 18 selects double-level operation.
- R3: Within a level field, bit 2 enables the PC condition. The PC matches when ((pc XOR base) AND NOT mask) is zero, so a mask bit of 1 means don't care. Bit 3 inverts the PC match.
- R4: Level field bits 4, 5 and 6 select, in that order: address equal to the low bound, address inside the inclusive low..high range, and address outside that range. The address condition is the OR of the selected tests. With all three bits clear, address matching is not used.
- R5: Level field bit 7 enables the data comparison against the data register. Bit 8 inverts it, so the level matches when the bus data differs from the programmed value. With bit 7 clear, the address-and-data term is the address condition alone.
- R6: Level field bit 1 selects the combining mode. 0 requires the enabled PC condition AND the enabled address-and-data term. 1 requires either one. A condition that is not enabled takes no part, and a level with no enabled comparator never fires.
- R7: Level field bit 0 is the level enable. When it is clear the level never fires, and for level 1 no `l1_hit` is reported.
- R8: Hits are reported only for cycles in which `acc_valid` is high. The output rises in the clock cycle after that access.
- R9: In single-level operation `trig` pulses together with `l1_hit`, and `l2_hit` stays low.
- R10: In double-level operation a level-1 hit arms the unit. Level 2 produces `l2_hit` and `trig` only on an access while armed, and firing disarms the unit. An access that matches both levels while disarmed only arms it.
- R11: Any register write disarms the unit and suppresses level-2 firing in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 3 | Configuration register select |
| wr_data | input | DW | Configuration write data |
| acc_valid | input | 1 | Retired access strobe |
| acc_pc | input | AW | Program counter of the access |
| acc_addr | input | AW | Bus address of the access |
| acc_data | input | DW | Bus data of the access |
| l1_hit | output | 1 | Level-1 match, registered |
| l2_hit | output | 1 | Level-2 match while armed, registered |
| trig | output | 1 | Final breakpoint trigger pulse |

## Verification
The bench walks the address bounds exactly: the high bound is inclusive, and one past it must fail. A design using a strict compare, or swapping the inside and outside tests, would miss or misreport those edges. It exercises the PC mask with addresses just inside and just outside the don't-care region, in both polarities. It also checks that a disabled condition is neutral in AND mode but not counted as a match in OR mode. Wrongly treating it as true would make OR-mode levels fire on every access.

For the sequencing, the bench checks four cases:
- An access matching both levels while disarmed must not trigger. A design that evaluates level 2 against the new armed state would fire early.
- A second matching access must not fire again after a trigger.
- A register write must disarm the unit.
- An access with the strobe low must neither arm nor fire.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;
  // One level's control field, LSB first: en, or_mode, pc_en, pc_inv,
  // addr_eq, addr_in, addr_out, data_en, data_inv.
  typedef struct packed {
    logic data_inv;
    logic data_en;
    logic addr_out;
    logic addr_in;
    logic addr_eq;
    logic pc_inv;
    logic pc_en;
    logic or_mode;
    logic en;
  } lvl_cfg_t;

  localparam int LVL_BITS = $bits(lvl_cfg_t);
  localparam int NUM_LVL  = 2;
  localparam int CTRL_W   = NUM_LVL * LVL_BITS + 1;
  localparam int DBL_BIT  = NUM_LVL * LVL_BITS;
  localparam int RAW      = 3;

  localparam logic [RAW-1:0] REG_CTRL  = 3'd0;
  localparam logic [RAW-1:0] REG_PCB   = 3'd1;
  localparam logic [RAW-1:0] REG_PCM   = 3'd2;
  localparam logic [RAW-1:0] REG_ALO   = 3'd3;
  localparam logic [RAW-1:0] REG_AHI   = 3'd4;
  localparam logic [RAW-1:0] REG_DVAL  = 3'd5;
endpackage

// File: rtl/dbg_trig_regs.sv
module dbg_trig_regs
  import dbg_trig_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [RAW-1:0]    wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [AW-1:0]     pc_base_q,
  output logic [AW-1:0]     pc_mask_q,
  output logic [AW-1:0]     addr_lo_q,
  output logic [AW-1:0]     addr_hi_q,
  output logic [DW-1:0]     data_val_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      pc_base_q  <= '0;
      pc_mask_q  <= '0;
      addr_lo_q  <= '0;
      addr_hi_q  <= '0;
      data_val_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        REG_CTRL: ctrl_q     <= wr_data[CTRL_W-1:0];
        REG_PCB:  pc_base_q  <= wr_data[AW-1:0];
        REG_PCM:  pc_mask_q  <= wr_data[AW-1:0];
        REG_ALO:  addr_lo_q  <= wr_data[AW-1:0];
        REG_AHI:  addr_hi_q  <= wr_data[AW-1:0];
        REG_DVAL: data_val_q <= wr_data;
        default:  ;
      endcase
    end
  end

  // R1: configuration is clear in the cycle after reset
  AST_RESET_CLEARS_CTRL: assert property (@(posedge clk) !rst_n |=> ctrl_q == '0); // R1
endmodule

// File: rtl/dbg_trig_level.sv
module dbg_trig_level
  import dbg_trig_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  lvl_cfg_t      cfg,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic [AW-1:0] pc_base,
  input  logic [AW-1:0] pc_mask,
  input  logic [AW-1:0] addr_lo,
  input  logic [AW-1:0] addr_hi,
  input  logic [DW-1:0] data_val,
  output logic          fire
);
  function automatic logic region_hit(input logic [AW-1:0] v, b, m);
    return ((v ^ b) & ~m) == '0;
  endfunction

  function automatic logic in_span(input logic [AW-1:0] v, lo, hi);
    return (v >= lo) && (v <= hi);
  endfunction

  // Named internal events
  logic pc_match, addr_span, addr_match, addr_on, data_match, ad_on, ad_ok;
  logic and_fire, or_fire;

  always_comb begin
    pc_match   = region_hit(pc, pc_base, pc_mask) ^ cfg.pc_inv;
    addr_span  = in_span(addr, addr_lo, addr_hi);
    addr_match = (cfg.addr_eq  && (addr == addr_lo)) ||
                 (cfg.addr_in  && addr_span) ||
                 (cfg.addr_out && !addr_span);
    addr_on    = cfg.addr_eq || cfg.addr_in || cfg.addr_out;
    data_match = (data == data_val) ^ cfg.data_inv;
    ad_on      = addr_on || cfg.data_en;
    ad_ok      = (!addr_on || addr_match) && (!cfg.data_en || data_match);
    and_fire   = (cfg.pc_en || ad_on) && (!cfg.pc_en || pc_match) && (!ad_on || ad_ok);
    or_fire    = (cfg.pc_en && pc_match) || (ad_on && ad_ok);
    fire       = cfg.en && (cfg.or_mode ? or_fire : and_fire);
  end
endmodule

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_valid,
  input  logic wr_en,
  input  logic dbl_mode,
  input  logic l1_fire,
  input  logic l2_fire,
  output logic l1_hit_q,
  output logic l2_hit_q,
  output logic trig_q,
  output logic armed_q
);
  logic l1_evt, l2_evt, armed_d;

  always_comb begin
    l1_evt = acc_valid && l1_fire;
    l2_evt = acc_valid && l2_fire && armed_q && dbl_mode && !wr_en;
    if (wr_en || !dbl_mode) armed_d = 1'b0;
    else if (armed_q)       armed_d = !l2_evt;
    else                    armed_d = l1_evt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l1_hit_q <= 1'b0;
      l2_hit_q <= 1'b0;
      trig_q   <= 1'b0;
      armed_q  <= 1'b0;
    end else begin
      l1_hit_q <= l1_evt;
      l2_hit_q <= l2_evt;
      trig_q   <= dbl_mode ? l2_evt : l1_evt;
      armed_q  <= armed_d;
    end
  end

  AST_IDLE_NO_HIT:  assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !l1_hit_q && !l2_hit_q && !trig_q); // R8
  AST_SINGLE_NO_L2: assert property (@(posedge clk) disable iff (!rst_n)
    !dbl_mode |=> !l2_hit_q); // R9
  AST_L2_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |=> !l2_hit_q); // R10
  AST_FIRE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    l2_hit_q |-> !armed_q); // R10
  AST_WR_DISARMS:   assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !armed_q && !l2_hit_q); // R11
endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit
  import dbg_trig_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_pc,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] acc_data,
  output logic          l1_hit,
  output logic          l2_hit,
  output logic          trig
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [AW-1:0]     pc_base_q, pc_mask_q, addr_lo_q, addr_hi_q;
  logic [DW-1:0]     data_val_q;
  lvl_cfg_t          cfg [NUM_LVL];
  logic [NUM_LVL-1:0] fire;
  logic              dbl_mode, armed_q;

  dbg_trig_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .pc_base_q(pc_base_q), .pc_mask_q(pc_mask_q),
    .addr_lo_q(addr_lo_q), .addr_hi_q(addr_hi_q), .data_val_q(data_val_q)
  );

  assign dbl_mode = ctrl_q[DBL_BIT];

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    assign cfg[g] = lvl_cfg_t'(ctrl_q[g*LVL_BITS +: LVL_BITS]);
    dbg_trig_level #(.AW(AW), .DW(DW)) u_level (
      .cfg(cfg[g]), .pc(acc_pc), .addr(acc_addr), .data(acc_data),
      .pc_base(pc_base_q), .pc_mask(pc_mask_q), .addr_lo(addr_lo_q),
      .addr_hi(addr_hi_q), .data_val(data_val_q), .fire(fire[g])
    );
  end

  dbg_trig_seq u_seq (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .wr_en(wr_en),
    .dbl_mode(dbl_mode), .l1_fire(fire[0]), .l2_fire(fire[1]),
    .l1_hit_q(l1_hit), .l2_hit_q(l2_hit), .trig_q(trig), .armed_q(armed_q)
  );

  AST_L1_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg[0].en |=> !l1_hit); // R7
  AST_ARM_NEEDS_L1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q && !fire[0] |=> !armed_q); // R10
endmodule

// File: tb/dbg_trig_unit_bench.sv
`timescale 1ns/1ps
module dbg_trig_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic        acc_valid;
  logic [31:0] acc_pc, acc_addr, acc_data;
  logic        l1_hit, l2_hit, trig;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dbg_trig_unit u_dbg_trig_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .acc_valid(acc_valid), .acc_pc(acc_pc), .acc_addr(acc_addr), .acc_data(acc_data),
    .l1_hit(l1_hit), .l2_hit(l2_hit), .trig(trig)
  );

  typedef struct packed {
    logic [31:0] ctrl;
    logic [31:0] pc;
    logic [31:0] addr;
    logic [31:0] data;
    logic        exp;
  } vec_t;

  // Single-level vectors; region base 0x1000 mask 0xFF, bounds 0x2000..0x20FF, data 0xCAFEF00D
  localparam vec_t VECS [0:18] = '{
    '{32'h005, 32'h1042, 32'h0,    32'h0,        1'b1}, // R3 inside region
    '{32'h005, 32'h1142, 32'h0,    32'h0,        1'b0}, // R3 outside region
    '{32'h00D, 32'h1142, 32'h0,    32'h0,        1'b1}, // R3 inverted
    '{32'h00D, 32'h10FF, 32'h0,    32'h0,        1'b0}, // R3 inverted, inside
    '{32'h011, 32'h0,    32'h2000, 32'h0,        1'b1}, // R4 equal low
    '{32'h011, 32'h0,    32'h2001, 32'h0,        1'b0}, // R4 not equal
    '{32'h021, 32'h0,    32'h20FF, 32'h0,        1'b1}, // R4 inclusive high
    '{32'h021, 32'h0,    32'h2100, 32'h0,        1'b0}, // R4 one past high
    '{32'h041, 32'h0,    32'h1FFF, 32'h0,        1'b1}, // R4 outside
    '{32'h041, 32'h0,    32'h2050, 32'h0,        1'b0}, // R4 outside, in range
    '{32'h0A1, 32'h0,    32'h2010, 32'hCAFEF00D, 1'b1}, // R5 data match
    '{32'h0A1, 32'h0,    32'h2010, 32'h0,        1'b0}, // R5 data mismatch
    '{32'h1A1, 32'h0,    32'h2010, 32'h0,        1'b1}, // R5 data inverted
    '{32'h025, 32'h1042, 32'h3000, 32'h0,        1'b0}, // R6 AND, addr fails
    '{32'h027, 32'h1042, 32'h3000, 32'h0,        1'b1}, // R6 OR, pc only
    '{32'h027, 32'h5000, 32'h2010, 32'h0,        1'b1}, // R6 OR, addr only
    '{32'h027, 32'h5000, 32'h3000, 32'h0,        1'b0}, // R6 OR, neither
    '{32'h024, 32'h1042, 32'h2010, 32'h0,        1'b0}, // R7 level disabled
    '{32'h001, 32'h1042, 32'h2010, 32'h0,        1'b0}  // R6 no comparator
  };

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Drive one access, then sample at the following negedge
  task automatic access(input logic v, input logic [31:0] pc, ad, dt);
    acc_valid = v; acc_pc = pc; acc_addr = ad; acc_data = dt;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    acc_valid = 1'b0; acc_pc = '0; acc_addr = '0; acc_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 l1_hit after reset", l1_hit, 1'b0);
    check("R1 trig after reset", trig, 1'b0);
    access(1'b1, 32'h1042, 32'h2000, 32'h0);
    check("R1 unconfigured access", l1_hit | l2_hit | trig, 1'b0);

    // R2: program the data-path registers
    wr(3'd1, 32'h1000); wr(3'd2, 32'h00FF);
    wr(3'd3, 32'h2000); wr(3'd4, 32'h20FF); wr(3'd5, 32'hCAFEF00D);

    for (int i = 0; i < 19; i++) begin
      wr(3'd0, VECS[i].ctrl);
      access(1'b1, VECS[i].pc, VECS[i].addr, VECS[i].data);
      check($sformatf("vector %0d l1_hit (R2 R3 R4 R5 R6 R7)", i), l1_hit, VECS[i].exp);
      check($sformatf("vector %0d trig follows l1 (R9)", i), trig, VECS[i].exp);
      check($sformatf("vector %0d l2 low (R9)", i), l2_hit, 1'b0);
      @(negedge clk);
      check($sformatf("vector %0d one-cycle result (R8)", i), l1_hit, 1'b0);
    end

    // R9: level 2 configured but single-level: no l2 hit
    wr(3'd0, 32'h02205);
    access(1'b1, 32'h1042, 32'h2000, 32'h0);
    check("R9 single l1", l1_hit, 1'b1);
    check("R9 single l2 stays low", l2_hit, 1'b0);

    // Double level: L1 = PC region, L2 = address equal low
    wr(3'd0, 32'h42205);
    access(1'b1, 32'h5000, 32'h2000, 32'h0);
    check("R10 l2 ignored while disarmed", l2_hit | trig, 1'b0);
    access(1'b1, 32'h1042, 32'h3000, 32'h0);
    check("R10 l1 arms", l1_hit, 1'b1);
    check("R10 no trig on arm", trig, 1'b0);
    access(1'b0, 32'h5000, 32'h2000, 32'h0);
    check("R8 strobe low no hit", l2_hit | trig, 1'b0);
    access(1'b1, 32'h5000, 32'h2000, 32'h0);
    check("R10 l2 fires when armed", l2_hit, 1'b1);
    check("R10 trig pulse", trig, 1'b1);
    access(1'b1, 32'h5000, 32'h2000, 32'h0);
    check("R10 disarmed after fire", trig, 1'b0);

    // Both levels on one access
    access(1'b1, 32'h1042, 32'h2000, 32'h0);
    check("R10 both-match access only arms", trig, 1'b0);
    check("R10 both-match l1", l1_hit, 1'b1);
    access(1'b1, 32'h1042, 32'h2000, 32'h0);
    check("R10 second access fires", trig, 1'b1);
    access(1'b1, 32'h1042, 32'h2000, 32'h0);
    check("R10 third access re-arms only", trig, 1'b0);

    // R11: write disarms (unit armed by previous access)
    wr(3'd5, 32'hCAFEF00D);
    access(1'b1, 32'h5000, 32'h2000, 32'h0);
    check("R11 write disarmed", trig, 1'b0);

    // R11: write in the same cycle as a level-2 access suppresses it
    access(1'b1, 32'h1042, 32'h3000, 32'h0);
    acc_valid = 1'b1; acc_pc = 32'h5000; acc_addr = 32'h2000;
    wr(3'd5, 32'hCAFEF00D);
    acc_valid = 1'b0;
    check("R11 same-cycle write suppresses l2", l2_hit | trig, 1'b0);

    finish_run();
  end
endmodule